// File: doc/BRIEF.md
# Interrupt Vector Relocation Unit

This unit sits on the exception delivery path. It decides whether an interrupt is taken at the relocated (alternate) handler location, and it produces the final 64-bit handler address and the final machine state word. For each request it receives the exception class, the current translation and hypervisor bits, the proposed new state word, the unrelocated base vector, the partition relocation controls and a processor generation select. Both results are registered and are flagged valid one clock after the request strobe.

Eligibility depends on the generation, on whether instruction and data translation are both on, and on whether the interrupt raises hypervisor state. The address offset depends on the resulting relocation level. The system-call-vectored class has its own offset rules. Before relocation, it is checked against a facility-enable input, and when that input is clear the request becomes a facility-unavailable exception with a fixed cause code.

Top module: `ivr_unit`

## Requirements
- R1: `out_valid` is high exactly in the cycle after a cycle with `req_valid` high. A synchronous active-low reset clears `out_valid` and all output registers to zero.
- R2: The class codes are 0 plain, 1 reset, 2 machine check, 3 hypervisor maintenance, 4 system-call-vectored and 5 facility-unavailable. For classes 1, 2 and 3 the vector and the state word are passed through unchanged on every generation.
- R3: On generations 1 and 2, relocation requires `cur_ir` and `cur_dr` both set. It is also refused when `cur_hv` is 0, new-state bit 60 (hypervisor) is 1 and `ctl_radix_host` is 0.
- R4: On generations 1 and 2, the level is `ctl_ail`. Values 0 and 1 give no relocation, 2 gives level 2 and 3 gives level 3.
- R5: On generation 3, relocation requires translation fully on, except that a hypervisor escalation (`cur_hv` 0, new bit 60 set) qualifies with any translation state.
- R6: On generation 3, when new bit 60 is set the level is 3 if `ctl_hv_ail` is 1 and none otherwise. When new bit 60 is clear, only `ctl_ail` = 3 relocates, at level 3.
- R7: Generation 0 never relocates.
- R8: When relocation applies, bits 5 (instruction translate) and 4 (data translate) of the output state word are set. All other state bits pass through unchanged.
- R9: For non-system-call-vectored classes, level 2 ORs 0x18000 into the vector and level 3 ORs 0xC000_0000_0000_4000 into it.
- R10: For class 4, level 2 leaves the vector unchanged. Level 3 clears the bits of 0x17000 and then ORs in 0xC000_0000_0000_3000.
- R11: A class-4 request with `fac_scv_en` low is output as class 5 with `out_cause` 0x0C and is relocated under the non-system-call-vectored rules. All other requests give `out_cause` 0 and keep their class.
- R12: While `req_valid` is low the output vector, state, class and cause registers hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe |
| exc_class | input | 3 | Exception class code |
| cur_ir | input | 1 | Current instruction translate bit |
| cur_dr | input | 1 | Current data translate bit |
| cur_hv | input | 1 | Current hypervisor bit |
| new_state | input | 64 | Proposed new machine state word |
| base_vec | input | 64 | Unrelocated handler address |
| ctl_ail | input | 2 | Partition relocation level field |
| ctl_radix_host | input | 1 | Partition radix-host bit |
| ctl_hv_ail | input | 1 | Hypervisor relocation enable |
| gen_sel | input | 2 | Processor generation (0 none, 1 and 2 older, 3 newest) |
| fac_scv_en | input | 1 | System-call-vectored facility enable |
| out_valid | output | 1 | Result valid |
| out_vec | output | 64 | Final handler address |
| out_state | output | 64 | Final machine state word |
| out_class | output | 3 | Class after facility check |
| out_cause | output | 8 | Facility-unavailable cause code |

## Verification
The hardest case to reach is a request that both escalates hypervisor state and has translation off on the newest generation. It is the only case where relocation applies with the MMU off. A second hard case is an escalation with relocation enabled that would relocate but for a never-relocate class. The vector table drives both outright. It pairs each of them with a neighbour row that differs in a single control bit, such as the hypervisor enable, the radix-host bit or the generation. A redirected system-call-vectored row also shows that the facility check runs before the offset rule is chosen.

// File: rtl/ivr_pkg.sv
// Package: shared codes and offset constants for the vector relocation unit.
// Assumes 64-bit addresses; offsets are architectural constants.
package ivr_pkg;
    typedef enum logic [2:0] {
        EXC_PLAIN  = 3'd0,
        EXC_RESET  = 3'd1,
        EXC_MCHK   = 3'd2,
        EXC_HMAINT = 3'd3,
        EXC_SCV    = 3'd4,
        EXC_FACUN  = 3'd5
    } exc_cls_t;

    typedef enum logic [1:0] {
        GEN_NONE  = 2'd0,
        GEN_OLD_A = 2'd1,
        GEN_OLD_B = 2'd2,
        GEN_NEW   = 2'd3
    } gen_t;

    typedef enum logic [1:0] {
        LVL_OFF  = 2'd0,
        LVL_RSV  = 2'd1,
        LVL_MID  = 2'd2,
        LVL_HIGH = 2'd3
    } lvl_t;

    localparam logic [63:0] OFS_MID      = 64'h0000_0000_0001_8000;
    localparam logic [63:0] OFS_HIGH     = 64'hC000_0000_0000_4000;
    localparam logic [63:0] SCV_BASE_MSK = 64'h0000_0000_0001_7000;
    localparam logic [63:0] SCV_HIGH     = 64'hC000_0000_0000_3000;
endpackage

// File: rtl/ivr_class_resolve.sv
// Module: applies the facility check to system-call-vectored requests.
// Assumes class codes from ivr_pkg; a disabled facility turns the request
// into a facility-unavailable exception with a fixed cause.
module ivr_class_resolve
    import ivr_pkg::*;
#(
    parameter int          CAUSE_W   = 8,
    parameter logic [7:0]  SCV_CAUSE = 8'h0C
) (
    input  logic                clk,
    input  logic                rst_n,
    input  exc_cls_t            cls_in,
    input  logic                fac_en,
    output exc_cls_t            cls_out,
    output logic [CAUSE_W-1:0]  cause_out
);
    logic redirect;

    // Decide whether the vectored system call is redirected.
    always_comb begin
        redirect  = (cls_in == EXC_SCV) && !fac_en;
        cls_out   = redirect ? EXC_FACUN : cls_in;
        cause_out = redirect ? CAUSE_W'(SCV_CAUSE) : '0;
    end

    // R11: a disabled facility never lets the vectored class through
    a_r11_redirect: assert property (@(posedge clk) disable iff (!rst_n)
        (cls_in == EXC_SCV && !fac_en) |-> (cls_out == EXC_FACUN && cause_out != '0));
endmodule

// File: rtl/ivr_level_sel.sv
// Module: decides the effective relocation level for one request.
// Assumes the class is already resolved; output is LVL_OFF, LVL_MID or LVL_HIGH.
module ivr_level_sel
    import ivr_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  exc_cls_t cls,
    input  logic     cur_ir,
    input  logic     cur_dr,
    input  logic     cur_hv,
    input  logic     new_hv,
    input  logic [1:0] ail,
    input  logic     radix_host,
    input  logic     hv_ail,
    input  gen_t     gen,
    output lvl_t     lvl
);
    logic mmu_on;
    logic escal;
    logic never_cls;
    lvl_t raw;

    // Per-generation eligibility and level selection.
    always_comb begin
        mmu_on    = cur_ir && cur_dr;
        escal     = !cur_hv && new_hv;
        never_cls = (cls == EXC_RESET) || (cls == EXC_MCHK) || (cls == EXC_HMAINT);
        raw       = LVL_OFF;
        case (gen)
            GEN_OLD_A, GEN_OLD_B: begin
                if (mmu_on && !(escal && !radix_host)) raw = lvl_t'(ail);
                if (raw == LVL_RSV) raw = LVL_OFF;
            end
            GEN_NEW: begin
                if (mmu_on || escal) begin
                    if (new_hv) raw = hv_ail ? LVL_HIGH : LVL_OFF;
                    else        raw = lvl_t'(ail);
                end
                if (raw != LVL_HIGH) raw = LVL_OFF;
            end
            default: raw = LVL_OFF;
        endcase
        lvl = never_cls ? LVL_OFF : raw;
    end

    // R2: excluded classes never get a level
    a_r2_never_cls: assert property (@(posedge clk) disable iff (!rst_n)
        (cls == EXC_RESET || cls == EXC_MCHK || cls == EXC_HMAINT) |-> lvl == LVL_OFF);
    // R3: older generations need translation fully on
    a_r3_old_mmu: assert property (@(posedge clk) disable iff (!rst_n)
        ((gen == GEN_OLD_A || gen == GEN_OLD_B) && !(cur_ir && cur_dr)) |-> lvl == LVL_OFF);
    // R3: older generations block escalation without radix host
    a_r3_old_escal: assert property (@(posedge clk) disable iff (!rst_n)
        ((gen == GEN_OLD_A || gen == GEN_OLD_B) && !cur_hv && new_hv && !radix_host)
        |-> lvl == LVL_OFF);
    // R6: newest generation hypervisor interrupts follow the enable bit
    a_r6_new_hv: assert property (@(posedge clk) disable iff (!rst_n)
        (gen == GEN_NEW && new_hv && !hv_ail) |-> lvl == LVL_OFF);
    // R7: generation 0 never relocates
    a_r7_legacy: assert property (@(posedge clk) disable iff (!rst_n)
        (gen == GEN_NONE) |-> lvl == LVL_OFF);
    // R4/R6: the reserved level never leaves this module
    a_r4_no_rsv: assert property (@(posedge clk) disable iff (!rst_n)
        lvl != LVL_RSV);
endmodule

// File: rtl/ivr_addr_apply.sv
// Module: applies the relocation level to the vector and the state word.
// Assumes lvl is never LVL_RSV; the vectored system call has its own rule.
module ivr_addr_apply
    import ivr_pkg::*;
#(
    parameter int VEC_W   = 64,
    parameter int STATE_W = 64,
    parameter int IR_POS  = 5,
    parameter int DR_POS  = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  exc_cls_t           cls,
    input  lvl_t               lvl,
    input  logic [VEC_W-1:0]   vec_in,
    input  logic [STATE_W-1:0] st_in,
    output logic [VEC_W-1:0]   vec_out,
    output logic [STATE_W-1:0] st_out
);
    localparam logic [STATE_W-1:0] XLATE_SET =
        (STATE_W'(1) << IR_POS) | (STATE_W'(1) << DR_POS);

    // Compute the relocated vector and the translation-on state word.
    always_comb begin
        vec_out = vec_in;
        st_out  = st_in;
        if (lvl != LVL_OFF) st_out = st_in | XLATE_SET;
        if (cls == EXC_SCV) begin
            if (lvl == LVL_HIGH)
                vec_out = (vec_in & ~VEC_W'(SCV_BASE_MSK)) | VEC_W'(SCV_HIGH);
        end else begin
            if (lvl == LVL_MID)       vec_out = vec_in | VEC_W'(OFS_MID);
            else if (lvl == LVL_HIGH) vec_out = vec_in | VEC_W'(OFS_HIGH);
        end
    end

    // R8: translation bits are on whenever a level applies
    a_r8_xlate_on: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl != LVL_OFF) |-> (st_out[IR_POS] && st_out[DR_POS]));
    // R10: level 2 vectored system call keeps its address
    a_r10_scv_mid: assert property (@(posedge clk) disable iff (!rst_n)
        (cls == EXC_SCV && lvl == LVL_MID) |-> vec_out == vec_in);
    // R9: ordinary level 3 lands in the high region
    a_r9_high_top: assert property (@(posedge clk) disable iff (!rst_n)
        (cls != EXC_SCV && lvl == LVL_HIGH) |-> vec_out[VEC_W-1 -: 2] == 2'b11);
    // R2: no level means untouched outputs
    a_r2_passthru: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl == LVL_OFF) |-> (vec_out == vec_in && st_out == st_in));
endmodule

// File: rtl/ivr_unit.sv
// Module: top of the interrupt vector relocation unit. Resolves the class,
// selects the level, applies offsets and registers the result one clock
// after req_valid. Synchronous active-low reset clears all outputs.
module ivr_unit
    import ivr_pkg::*;
#(
    parameter int         VEC_W     = 64,
    parameter int         STATE_W   = 64,
    parameter int         IR_POS    = 5,
    parameter int         DR_POS    = 4,
    parameter int         HV_POS    = 60,
    parameter int         CAUSE_W   = 8,
    parameter logic [7:0] SCV_CAUSE = 8'h0C
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic [2:0]         exc_class,
    input  logic               cur_ir,
    input  logic               cur_dr,
    input  logic               cur_hv,
    input  logic [STATE_W-1:0] new_state,
    input  logic [VEC_W-1:0]   base_vec,
    input  logic [1:0]         ctl_ail,
    input  logic               ctl_radix_host,
    input  logic               ctl_hv_ail,
    input  logic [1:0]         gen_sel,
    input  logic               fac_scv_en,
    output logic               out_valid,
    output logic [VEC_W-1:0]   out_vec,
    output logic [STATE_W-1:0] out_state,
    output logic [2:0]         out_class,
    output logic [CAUSE_W-1:0] out_cause
);
    exc_cls_t           cls_res;
    logic [CAUSE_W-1:0] cause_res;
    lvl_t               lvl;
    logic [VEC_W-1:0]   vec_nx;
    logic [STATE_W-1:0] st_nx;

    ivr_class_resolve #(.CAUSE_W(CAUSE_W), .SCV_CAUSE(SCV_CAUSE)) u_cls (
        .clk(clk), .rst_n(rst_n),
        .cls_in(exc_cls_t'(exc_class)), .fac_en(fac_scv_en),
        .cls_out(cls_res), .cause_out(cause_res)
    );

    ivr_level_sel u_lvl (
        .clk(clk), .rst_n(rst_n), .cls(cls_res),
        .cur_ir(cur_ir), .cur_dr(cur_dr), .cur_hv(cur_hv),
        .new_hv(new_state[HV_POS]), .ail(ctl_ail),
        .radix_host(ctl_radix_host), .hv_ail(ctl_hv_ail),
        .gen(gen_t'(gen_sel)), .lvl(lvl)
    );

    ivr_addr_apply #(.VEC_W(VEC_W), .STATE_W(STATE_W),
                     .IR_POS(IR_POS), .DR_POS(DR_POS)) u_apply (
        .clk(clk), .rst_n(rst_n), .cls(cls_res), .lvl(lvl),
        .vec_in(base_vec), .st_in(new_state),
        .vec_out(vec_nx), .st_out(st_nx)
    );

    // Output valid flag follows the request strobe by one clock.
    always_ff @(posedge clk) begin
        if (!rst_n) out_valid <= 1'b0;
        else        out_valid <= req_valid;
    end

    // Result registers load on a request and hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_vec   <= '0;
            out_state <= '0;
            out_class <= '0;
            out_cause <= '0;
        end else if (req_valid) begin
            out_vec   <= vec_nx;
            out_state <= st_nx;
            out_class <= cls_res;
            out_cause <= cause_res;
        end
    end

    // R1: valid appears one clock after a request
    a_r1_valid_rise: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> out_valid);
    // R1: no request, no valid
    a_r1_valid_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !out_valid);
    // R12: results hold without a request
    a_r12_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> ($stable(out_vec) && $stable(out_state) && $stable(out_class)));
endmodule

// File: tb/sim_ivr_unit.sv
// Bench: table-driven check of the relocation unit, then directed tests
// for reset, hold and reset during a request.
module sim_ivr_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [2:0]  exc_class = '0;
    logic        cur_ir = 1'b0, cur_dr = 1'b0, cur_hv = 1'b0;
    logic [63:0] new_state = '0;
    logic [63:0] base_vec = '0;
    logic [1:0]  ctl_ail = '0;
    logic        ctl_radix_host = 1'b0, ctl_hv_ail = 1'b0;
    logic [1:0]  gen_sel = '0;
    logic        fac_scv_en = 1'b0;
    logic        out_valid;
    logic [63:0] out_vec, out_state;
    logic [2:0]  out_class;
    logic [7:0]  out_cause;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    ivr_unit u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .exc_class(exc_class),
        .cur_ir(cur_ir), .cur_dr(cur_dr), .cur_hv(cur_hv),
        .new_state(new_state), .base_vec(base_vec), .ctl_ail(ctl_ail),
        .ctl_radix_host(ctl_radix_host), .ctl_hv_ail(ctl_hv_ail),
        .gen_sel(gen_sel), .fac_scv_en(fac_scv_en),
        .out_valid(out_valid), .out_vec(out_vec), .out_state(out_state),
        .out_class(out_class), .out_cause(out_cause)
    );

    // Fields: cls ir dr hv nhv ail rh ha gen fac | exp_lvl exp_cls
    localparam int N = 24;
    localparam logic [18:0] TBL [N] = '{
        19'b000_1_1_0_0_11_0_0_01_0_11_000, // R4 R9 gen1 level 3
        19'b000_1_1_0_0_10_0_0_10_0_10_000, // R4 R9 gen2 level 2
        19'b000_1_1_0_0_01_0_0_01_0_00_000, // R4 reserved value
        19'b000_1_1_0_0_00_0_0_10_0_00_000, // R4 zero
        19'b000_1_0_0_0_11_0_0_01_0_00_000, // R3 data translate off
        19'b000_1_1_0_1_11_0_0_01_0_00_000, // R3 escalation, no radix host
        19'b000_1_1_0_1_11_1_0_10_0_11_000, // R3 escalation, radix host
        19'b000_1_1_1_1_10_0_0_01_0_10_000, // R3 hv stays set
        19'b001_1_1_0_0_11_0_0_01_0_00_001, // R2 reset class
        19'b010_1_1_0_1_00_0_1_11_0_00_010, // R2 machine check would qualify
        19'b011_1_1_0_0_11_0_0_10_0_00_011, // R2 hyp maintenance
        19'b000_1_1_0_0_11_0_1_00_0_00_000, // R7 generation 0
        19'b000_1_1_0_0_10_0_0_11_0_00_000, // R6 newest level 2 is off
        19'b000_1_1_0_0_11_0_0_11_0_11_000, // R6 R9 newest level 3
        19'b000_0_1_0_0_11_0_0_11_0_00_000, // R5 translate off, no escalation
        19'b000_0_0_0_1_00_0_1_11_0_11_000, // R5 R6 escalation with MMU off
        19'b000_1_1_0_1_11_0_0_11_0_00_000, // R6 hv enable clear
        19'b000_0_0_1_1_00_0_1_11_0_00_000, // R5 hv to hv needs MMU
        19'b000_1_1_1_1_00_0_1_11_0_11_000, // R6 hv to hv with MMU
        19'b100_1_1_0_0_10_0_0_01_1_10_100, // R10 vectored level 2
        19'b100_1_1_0_0_11_0_0_11_1_11_100, // R10 vectored level 3
        19'b100_1_1_0_0_11_0_0_11_0_11_101, // R11 redirect, relocated
        19'b100_1_1_0_0_11_0_0_00_0_00_101, // R11 redirect, gen 0
        19'b100_0_1_0_0_11_0_0_11_1_00_100  // R10 vectored, MMU off
    };

    task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Expected vector from R9, R10, R11 rules.
    function automatic logic [63:0] exp_vec(input logic [2:0] ecls, input logic [1:0] lvl,
                                            input logic [63:0] b);
        if (ecls == 3'd4)
            return (lvl == 2'd3) ? ((b & ~64'h17000) | 64'hC000_0000_0000_3000) : b;
        if (lvl == 2'd2) return b | 64'h18000;
        if (lvl == 2'd3) return b | 64'hC000_0000_0000_4000;
        return b;
    endfunction

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : main
        logic [63:0] sbase, ev, es;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(out_valid == 1'b0, "R1 reset valid", {63'd0, out_valid}, 64'd0);
        chk(out_vec == '0, "R1 reset vec", out_vec, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < N; i++) begin
            logic [18:0] e;
            e = TBL[i];
            exc_class      = e[18:16];
            cur_ir         = e[15];
            cur_dr         = e[14];
            cur_hv         = e[13];
            sbase          = 64'h0000_0000_0000_0001 | (64'(e[12]) << 60) | (64'(i) << 8);
            new_state      = sbase;
            base_vec       = (e[18:16] == 3'd4) ? 64'h17040 : 64'h700;
            ctl_ail        = e[11:10];
            ctl_radix_host = e[9];
            ctl_hv_ail     = e[8];
            gen_sel        = e[7:6];
            fac_scv_en     = e[5];
            req_valid      = 1'b1;
            ev = exp_vec(e[2:0], e[4:3], base_vec);
            es = (e[4:3] != 2'd0) ? (sbase | 64'h30) : sbase;  // R8
            @(negedge clk);
            req_valid = 1'b0;
            chk(out_valid == 1'b1, $sformatf("R1 row %0d valid", i), {63'd0, out_valid}, 64'd1);
            chk(out_vec == ev, $sformatf("R9/R10 row %0d vec", i), out_vec, ev);
            chk(out_state == es, $sformatf("R8 row %0d state", i), out_state, es);
            chk(out_class == e[2:0], $sformatf("R11 row %0d class", i),
                {61'd0, out_class}, {61'd0, e[2:0]});
            chk(out_cause == ((e[2:0] == 3'd5) ? 8'h0C : 8'h00),
                $sformatf("R11 row %0d cause", i), {56'd0, out_cause},
                (e[2:0] == 3'd5) ? 64'h0C : 64'h0);
        end

        // R12: changed inputs without a strobe leave outputs held
        ev = out_vec;
        es = out_state;
        base_vec  = 64'h900;
        new_state = 64'h5;
        exc_class = 3'd0;
        gen_sel   = 2'd3;
        @(negedge clk);
        @(negedge clk);
        chk(out_valid == 1'b0, "R1 idle valid", {63'd0, out_valid}, 64'd0);
        chk(out_vec == ev, "R12 hold vec", out_vec, ev);
        chk(out_state == es, "R12 hold state", out_state, es);

        // R1: reset while a request is presented clears outputs
        req_valid = 1'b1;
        rst_n     = 1'b0;
        @(negedge clk);
        chk(out_valid == 1'b0, "R1 reset with request", {63'd0, out_valid}, 64'd0);
        chk(out_vec == '0, "R1 reset clears vec", out_vec, 64'd0);
        req_valid = 1'b0;
        rst_n     = 1'b1;
        @(negedge clk);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule